// File: doc/BRIEF.md
# Serial-Bus Controlled Wiper Register with Shutdown

This block is the digital half of a 256-step potentiometer. It is a two-wire serial-bus slave (I2C-compatible, standard and fast mode) that owns one 8-bit tap code, which the resistor array decodes. It also owns one shutdown flag, which disconnects the array's top terminal. The host writes a command byte and a tap byte, and it reads the tap code back. One strap input supplies the low bit of the slave address, so two of these blocks can share one bus.

Both bus lines are brought into the system-clock domain through two-flop synchronisers. A further flop per line supplies the previous value for edge detection. START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. The block drives SDA only by asserting an open-drain pull-down enable. A link state machine decodes each frame and emits single-cycle write pulses toward the wiper register.

The link states are: ST_IDLE (bus free), ST_ADDR (receive address byte), ST_ADDR_ACK, ST_CMD (receive command byte), ST_CMD_ACK, ST_DATA (receive tap byte), ST_DATA_ACK, ST_TX (send tap byte), ST_TX_ACK (sample the host's acknowledge) and ST_IGNORE (stay off the bus until the next START or STOP). The transitions are as follows. START from any state goes to ST_ADDR, and STOP from any state goes to ST_IDLE. ST_ADDR goes to ST_ADDR_ACK on a match and to ST_IGNORE otherwise. ST_ADDR_ACK goes to ST_CMD for a write or to ST_TX for a read. The chain continues ST_CMD, ST_CMD_ACK, ST_DATA, ST_DATA_ACK, and then ST_IGNORE. ST_TX goes to ST_TX_ACK. ST_TX_ACK returns to ST_TX if the host acknowledged and goes to ST_IGNORE if it did not.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: After reset the tap code is 0x80, the shutdown flag is 0 and the SDA pull-down enable is 0.
- R2: The 7-bit slave address is 0b010110 followed by the address-select input as its LSB. With select low, the write address byte is 0x58 and the read address byte is 0x59. With select high, they are 0x5A and 0x5B.
- R3: A write frame is the address byte with bit 0 = 0, then a command byte, then a tap byte. When command bit 6 is 0, the tap byte replaces the tap code. The block acknowledges all three bytes.
- R4: The block acknowledges a byte by pulling SDA low for the ninth clock. It changes its SDA drive from released to pulled low only while SCL is low.
- R5: A read frame is the address byte with bit 0 = 1. The block then sends the tap code MSB first. It sends the code again after each host acknowledge, and it releases SDA after a host not-acknowledge.
- R6: When the address does not match, the block leaves SDA released and changes nothing until the next START or STOP.
- R7: Command bit 6 = 1 sets the tap code to 0x80. A tap byte that follows in the same frame is acknowledged but discarded.
- R8: Command bit 5 is copied into the shutdown flag. The tap code is kept and stays readable while the flag is 1.
- R9: The tap code and the shutdown flag change only when a command byte or a tap byte is received. A frame that ends after its command byte applies only the command.
- R10: STOP ends any frame with SDA released. A repeated START begins a new address phase.
- R11: Bytes that follow the tap byte in a write frame are not acknowledged and have no effect.
- R12: The extreme tap codes 0x00 and 0xFF are written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel_i | input | 1 | Strap input, LSB of the slave address |
| sda_oe_o | output | 1 | 1 = pull SDA low (open drain) |
| tap_o | output | 8 | Tap code to the resistor array |
| sleep_o | output | 1 | 1 = shutdown, top terminal open |

## Verification
The in-RTL assertions watch four things on every cycle. SDA is never newly pulled low while SCL is high. STOP, ST_IDLE and ST_IGNORE always leave SDA released. The command and tap write pulses never coincide. The tap code and the shutdown flag move only in the cycle after a write pulse, and then only to midscale, to the received byte or to the received command bit. Whole-frame behaviour can only be shown by the bench scenarios driving real bus waveforms: address matching for both strap values, the discarded tap byte after a midscale command, read-back during shutdown, repeated reads under host acknowledge, bytes past the tap byte going unacknowledged, and a repeated START between frames.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CNT_W     = $clog2(BYTE_W + 1);
    localparam int unsigned CMD_MID_B = 6;
    localparam int unsigned CMD_OFF_B = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } link_state_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] now_o,
    output logic [LINES-1:0] prev_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[DEPTH-2:0], raw_i[g]};
        end
        assign now_o[g]  = chain_q[STAGES-1];
        assign prev_o[g] = chain_q[STAGES];
    end
endmodule

// File: rtl/dpot_link.sv
module dpot_link
    import dpot_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b010110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_d,
    input  logic              sda_s,
    input  logic              sda_d,
    input  logic              sel_i,
    input  logic [BYTE_W-1:0] rd_code_i,
    output logic              sda_oe_o,
    output logic              cmd_we_o,
    output logic              data_we_o,
    output logic [BYTE_W-1:0] wr_byte_o
);
    link_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] rx_sh_q, tx_sh_q;
    logic              mid_q, m_ack_q;

    logic scl_rise, scl_fall, start_ev, stop_ev, byte_done, addr_hit;
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_ev  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev   = scl_s & scl_d & ~sda_d & sda_s;
    assign byte_done = scl_fall && (bit_cnt_q == CNT_W'(BYTE_W));
    assign addr_hit  = (rx_sh_q[BYTE_W-1:1] == {ADDR_HI, sel_i});
    assign wr_byte_o = rx_sh_q;

    always_comb begin
        state_d = state_q;
        if (start_ev)     state_d = ST_ADDR;
        else if (stop_ev) state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_d = rx_sh_q[0] ? ST_TX : ST_CMD;
                ST_CMD:      if (byte_done) state_d = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall)  state_d = ST_DATA;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_d = ST_IGNORE;
                ST_TX:       if (byte_done) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall)  state_d = m_ack_q ? ST_TX : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
            mid_q     <= 1'b0;
            m_ack_q   <= 1'b0;
            sda_oe_o  <= 1'b0;
            cmd_we_o  <= 1'b0;
            data_we_o <= 1'b0;
        end else begin
            cmd_we_o  <= 1'b0;
            data_we_o <= 1'b0;
            if (start_ev) begin
                bit_cnt_q <= '0;
                sda_oe_o  <= 1'b0;
            end else if (stop_ev) begin
                sda_oe_o  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_CMD, ST_DATA: begin
                        if (scl_rise) begin
                            rx_sh_q   <= {rx_sh_q[BYTE_W-2:0], sda_s};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (byte_done) begin
                            if (state_q != ST_ADDR || addr_hit) sda_oe_o <= 1'b1;
                            if (state_q == ST_CMD) begin
                                cmd_we_o <= 1'b1;
                                mid_q    <= rx_sh_q[CMD_MID_B];
                            end
                            if (state_q == ST_DATA) data_we_o <= ~mid_q;
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (rx_sh_q[0]) begin
                            tx_sh_q  <= rd_code_i;
                            sda_oe_o <= ~rd_code_i[BYTE_W-1];
                        end else begin
                            sda_oe_o <= 1'b0;
                        end
                    end
                    ST_CMD_ACK: if (scl_fall) begin
                        bit_cnt_q <= '0;
                        sda_oe_o  <= 1'b0;
                    end
                    ST_DATA_ACK: if (scl_fall) sda_oe_o <= 1'b0;
                    ST_TX: begin
                        if (scl_rise) bit_cnt_q <= bit_cnt_q + 1'b1;
                        else if (byte_done) sda_oe_o <= 1'b0;
                        else if (scl_fall) begin
                            tx_sh_q  <= tx_sh_q << 1;
                            sda_oe_o <= ~tx_sh_q[BYTE_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) m_ack_q <= ~sda_s;
                        else if (scl_fall && m_ack_q) begin
                            bit_cnt_q <= '0;
                            tx_sh_q   <= rd_code_i;
                            sda_oe_o  <= ~rd_code_i[BYTE_W-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: a new pull-down only starts while SCL is low
    a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);
    // R10: STOP always leaves the line released
    a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o);
    // R6: idle or ignoring means hands off the bus
    a_r6_quiet_states: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !sda_oe_o);
    // R3: command and tap writes are separate events
    a_r3_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_we_o, data_we_o}));
endmodule

// File: rtl/dpot_wiper.sv
module dpot_wiper
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we_i,
    input  logic              data_we_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    output logic [BYTE_W-1:0] tap_o,
    output logic              sleep_o
);
    localparam logic [BYTE_W-1:0] MIDSCALE = BYTE_W'(1) << (BYTE_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_o   <= MIDSCALE;
            sleep_o <= 1'b0;
        end else if (cmd_we_i) begin
            if (wr_byte_i[CMD_MID_B]) tap_o <= MIDSCALE;
            sleep_o <= wr_byte_i[CMD_OFF_B];
        end else if (data_we_i) begin
            tap_o <= wr_byte_i;
        end
    end

    // R7: midscale command lands on 0x80
    a_r7_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_i && wr_byte_i[CMD_MID_B]) |=> tap_o == MIDSCALE);
    // R8: shutdown flag follows the command bit
    a_r8_sleep_bit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we_i |=> sleep_o == $past(wr_byte_i[CMD_OFF_B]));
    // R3: tap byte is loaded as received
    a_r3_tap_load: assert property (@(posedge clk) disable iff (!rst_n)
        data_we_i |=> tap_o == $past(wr_byte_i));
    // R9: no write pulse, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we_i && !data_we_i) |=> ($stable(tap_o) && $stable(sleep_o)));
endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl
    import dpot_pkg::*;
#(
    parameter logic [5:0]  ADDR_HI   = 6'b010110,
    parameter int unsigned SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] tap_o,
    output logic              sleep_o
);
    logic [1:0]        line_now, line_prev;
    logic              cmd_we, data_we;
    logic [BYTE_W-1:0] wr_byte;

    dpot_sync #(.LINES(2), .STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .now_o  (line_now),
        .prev_o (line_prev)
    );

    dpot_link #(.ADDR_HI(ADDR_HI)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_now[1]),
        .scl_d     (line_prev[1]),
        .sda_s     (line_now[0]),
        .sda_d     (line_prev[0]),
        .sel_i     (addr_sel_i),
        .rd_code_i (tap_o),
        .sda_oe_o  (sda_oe_o),
        .cmd_we_o  (cmd_we),
        .data_we_o (data_we),
        .wr_byte_o (wr_byte)
    );

    dpot_wiper u_wiper (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we_i  (cmd_we),
        .data_we_i (data_we),
        .wr_byte_i (wr_byte),
        .tap_o     (tap_o),
        .sleep_o   (sleep_o)
    );
endmodule

// File: tb/dpot_i2c_ctrl_tb.sv
`timescale 1ns/1ps
module dpot_i2c_ctrl_tb_top;
    localparam int Q      = 200;
    localparam int WD_NS  = 200000 * 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sel = 1'b0;
    logic sda_oe;
    logic [7:0] tap;
    logic sleep;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dpot_i2c_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_sel_i (sel),
        .sda_oe_o   (sda_oe),
        .tap_o      (tap),
        .sleep_o    (sleep)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #(Q); scl_m = 1'b1; #(Q); sda_m = 1'b0; #(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        #(Q); sda_m = 1'b0; #(Q); scl_m = 1'b1; #(Q); sda_m = 1'b1; #(2*Q);
    endtask

    task automatic put_bit(input logic b);
        #(Q); sda_m = b; #(Q); scl_m = 1'b1; #(2*Q); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        #(Q); sda_m = 1'b1; #(Q); scl_m = 1'b1; #(Q); b = sda_bus; #(Q); scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic write3(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                          output logic k0, output logic k1, output logic k2);
        bus_start();
        put_byte(a, k0);
        put_byte(c, k1);
        put_byte(d, k2);
        bus_stop();
    endtask

    task automatic read1(input logic [7:0] a, output logic k, output logic [7:0] v);
        bus_start();
        put_byte(a, k);
        get_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1", "tap after reset", tap, 8'h80);
        chk("R1", "sleep after reset", sleep, 0);
        chk("R1", "sda drive after reset", sda_oe, 0);
    endtask

    task automatic t_basic_write();
        logic k0, k1, k2;
        write3(8'h58, 8'h00, 8'h3C, k0, k1, k2);
        chk("R2", "address 0x58 acked", k0, 1);
        chk("R3", "command acked", k1, 1);
        chk("R4", "tap byte acked", k2, 1);
        chk("R3", "tap loaded", tap, 8'h3C);
        chk("R10", "released after stop", sda_oe, 0);
    endtask

    task automatic t_read_back();
        logic k;
        logic [7:0] v;
        read1(8'h59, k, v);
        chk("R5", "read address acked", k, 1);
        chk("R5", "read value", v, 8'h3C);
    endtask

    task automatic t_wrong_addr();
        logic k0, k1, k2;
        write3(8'h5A, 8'h40, 8'h11, k0, k1, k2);
        chk("R6", "foreign address not acked", k0, 0);
        chk("R6", "following byte not acked", k1, 0);
        chk("R6", "tap untouched", tap, 8'h3C);
    endtask

    task automatic t_sel_high();
        logic k0, k1, k2, k;
        logic [7:0] v;
        sel = 1'b1;
        #(4*Q);
        write3(8'h58, 8'h00, 8'h22, k0, k1, k2);
        chk("R2", "old address ignored with sel high", k0, 0);
        write3(8'h5A, 8'h00, 8'hA5, k0, k1, k2);
        chk("R2", "address 0x5A acked", k0, 1);
        chk("R2", "tap via 0x5A", tap, 8'hA5);
        read1(8'h5B, k, v);
        chk("R2", "read via 0x5B", v, 8'hA5);
        sel = 1'b0;
        #(4*Q);
    endtask

    task automatic t_midscale();
        logic k0, k1, k2;
        write3(8'h58, 8'h40, 8'h11, k0, k1, k2);
        chk("R7", "tap byte still acked", k2, 1);
        chk("R7", "tap at midscale, data discarded", tap, 8'h80);
    endtask

    task automatic t_shutdown();
        logic k0, k1, k;
        logic [7:0] v;
        write3(8'h58, 8'h00, 8'h5E, k0, k1, k);
        bus_start();
        put_byte(8'h58, k0);
        put_byte(8'h20, k1);
        bus_stop();
        chk("R8", "sleep set", sleep, 1);
        chk("R9", "tap kept after command-only frame", tap, 8'h5E);
        read1(8'h59, k, v);
        chk("R8", "readable while asleep", v, 8'h5E);
        bus_start();
        put_byte(8'h58, k0);
        put_byte(8'h00, k1);
        bus_stop();
        chk("R8", "sleep cleared", sleep, 0);
        chk("R9", "previous code restored", tap, 8'h5E);
    endtask

    task automatic t_multi_read();
        logic k;
        logic [7:0] v0, v1;
        bus_start();
        put_byte(8'h59, k);
        get_byte(1'b1, v0);
        get_byte(1'b0, v1);
        #(Q);
        chk("R5", "released after host nack", sda_oe, 0);
        bus_stop();
        chk("R5", "first read byte", v0, 8'h5E);
        chk("R5", "repeat after host ack", v1, 8'h5E);
    endtask

    task automatic t_extra_bytes();
        logic k0, k1, k2, k3;
        bus_start();
        put_byte(8'h58, k0);
        put_byte(8'h00, k1);
        put_byte(8'h77, k2);
        put_byte(8'h12, k3);
        bus_stop();
        chk("R11", "extra byte not acked", k3, 0);
        chk("R11", "tap from first data byte", tap, 8'h77);
    endtask

    task automatic t_boundary();
        logic k0, k1, k2, k;
        logic [7:0] v;
        write3(8'h58, 8'h00, 8'h00, k0, k1, k2);
        read1(8'h59, k, v);
        chk("R12", "code 0x00 read", v, 8'h00);
        chk("R12", "code 0x00 tap", tap, 8'h00);
        write3(8'h58, 8'h00, 8'hFF, k0, k1, k2);
        read1(8'h59, k, v);
        chk("R12", "code 0xFF read", v, 8'hFF);
    endtask

    task automatic t_restart();
        logic k0, k1, k2;
        logic [7:0] v;
        bus_start();
        put_byte(8'h58, k0);
        put_byte(8'h00, k1);
        bus_start();
        put_byte(8'h59, k2);
        get_byte(1'b0, v);
        bus_stop();
        chk("R10", "read after repeated start acked", k2, 1);
        chk("R10", "read after repeated start", v, 8'hFF);
        chk("R10", "released at end", sda_oe, 0);
    endtask

    initial begin
        #(WD_NS);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(105);
        rst_n = 1'b1;
        #(4*Q);
        t_reset();
        t_basic_write();
        t_read_back();
        t_wrong_addr();
        t_sel_high();
        t_midscale();
        t_shutdown();
        t_multi_read();
        t_extra_bytes();
        t_boundary();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule